// File: doc/BRIEF.md
# Indirect Register and Table Access Bridge

This block gives a small I/O port space a path into two much larger internal spaces: a register space and a separate translation-table memory. The host sees only two 32-bit locations. The first location is a pointer. It holds a dword offset and a 2-bit code that picks the destination space. The second location is a window. Every full-width read or write on the window is sent, as one request, to the location that the pointer currently names.

The host side is a simple slave port. It has a select bit that chooses pointer or window, write and read strobes, byte enables and 32-bit data. The port shows `ioReady` while it can take an access. Read results come back on `ioRdData`, qualified by a one-cycle `ioRdValid`. Each downstream space has its own request port with a valid/ready handshake. A read returns its data on a response strobe. A write needs no response.

The bridge drops some accesses instead of forwarding them: those with a reserved destination code, those with partial byte enables, and register-space accesses that fall in a configurable window of offsets that must be reached through dedicated legacy ports. In each of these cases a read returns zero.

Top module: `idxWindowBridge`

## Requirements
- R1: After reset the pointer reads as 00000000h, `ioReady` is high and neither downstream request valid is asserted.
- R2: A pointer write (`ioSelData`=0) updates each byte lane whose `ioBe` bit is set. Bits 31:21 always read as zero. A pointer read returns the stored value with `ioRdValid` high in the cycle after the access is accepted.
- R3: Pointer bits 1:0 are the destination code: 00 selects the register port and 01 selects the table port. Pointer bits 20:2 are sent unchanged as the 19-bit dword offset on the selected port.
- R4: A window write (`ioSelData`=1) with `ioBe`=1111 issues exactly one downstream write that carries `ioWrData`. A window read with `ioBe`=1111 issues one downstream read and returns the response data on `ioRdData`.
- R5: With destination code 10 or 11, a window write issues no downstream request and a window read returns 00000000h.
- R6: A register-space window access whose offset lies in [EXCL_LO, EXCL_HI] (default 40h..4Fh) issues no request and reads as 00000000h. The same offsets in the table space are forwarded.
- R7: A window access with any `ioBe` value other than 1111 issues no request. Such a write changes nothing and such a read returns 00000000h.
- R8: From the acceptance of a forwarded window access until it completes, `ioReady` stays low. The downstream request stays asserted with stable offset and data until the target accepts it.
- R9: The pointer is captured when a window access is accepted. A pointer write presented during the stall is taken only afterwards and changes only later window accesses.
- R10: At most one of the two downstream request valids is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioSelData | input | 1 | 0 = pointer location (offsets 0h-3h), 1 = window (offsets 4h-7h) |
| ioWrEn | input | 1 | Host write strobe |
| ioRdEn | input | 1 | Host read strobe |
| ioBe | input | 4 | Host byte enables |
| ioWrData | input | 32 | Host write data |
| ioReady | output | 1 | Bridge can take an access this cycle |
| ioRdValid | output | 1 | Read result valid (one cycle) |
| ioRdData | output | 32 | Read result |
| regReqValid | output | 1 | Register-space request valid |
| regReqReady | input | 1 | Register space accepts the request |
| regReqWrite | output | 1 | Request is a write |
| regReqOffset | output | 19 | Dword offset in register space |
| regReqData | output | 32 | Write data to register space |
| regRspValid | input | 1 | Register-space read response valid |
| regRspData | input | 32 | Register-space read data |
| tblReqValid | output | 1 | Table request valid |
| tblReqReady | input | 1 | Table accepts the request |
| tblReqWrite | output | 1 | Request is a write |
| tblReqOffset | output | 19 | Dword offset in the table |
| tblReqData | output | 32 | Write data to the table |
| tblRspValid | input | 1 | Table read response valid |
| tblRspData | input | 32 | Table read data |

## Verification
If the held pointer is corrupted, the fault shows at the host port on the next pointer read. It also shows on the next window access: either as a request on the wrong downstream port or with the wrong offset, or as a zero read where real data was expected. If the controller's state is wrong, `ioReady` stays stuck low, or a second access slips in while a request is still outstanding. A stuck-low `ioReady` is seen within a few cycles as a host access that is never accepted. Several checks watch for this case. The bench sweeps every byte-enable value, every destination code, and offsets on both sides of the excluded window. It compares both the host read data and the downstream request counts against values it computes itself.

// File: rtl/idxBridgePkg.sv
package idxBridgePkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_IDX  = 2'd1,
    RD_RSP  = 2'd2
  } rdSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   idxWr;      // update pointer from host data
    logic   capture;    // latch pointer and write data for a forwarded access
    logic   reqActive;  // downstream request is being presented
    logic   rdLoad;     // load a host read result
    rdSrc_t rdSrc;      // where the read result comes from
  } ctrlStrb_t;

endpackage

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import idxBridgePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioSelData,
  input  logic       ioWrEn,
  input  logic       ioRdEn,
  input  logic       ioFullBe,
  input  logic [1:0] idxTarget,
  input  logic       idxExcluded,
  input  logic       dsReady,
  input  logic       dsRspValid,
  output logic       ioReady,
  output ctrlStrb_t  strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} state_t;

  state_t state, nextState;
  logic   pendWrite;
  logic   accept;
  logic   forward;

  assign ioReady = (state == ST_IDLE);
  assign accept  = ioReady && (ioWrEn || ioRdEn);
  assign forward = ioSelData && ioFullBe && !idxTarget[1] &&
                   !((idxTarget == 2'b00) && idxExcluded);

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!ioSelData) begin
            if (ioWrEn) begin
              strb.idxWr = 1'b1;
            end else begin
              strb.rdLoad = 1'b1;
              strb.rdSrc  = RD_IDX;
            end
          end else if (forward) begin
            strb.capture = 1'b1;
            nextState    = ST_REQ;
          end else if (!ioWrEn) begin
            strb.rdLoad = 1'b1;
            strb.rdSrc  = RD_ZERO;
          end
        end
      end
      ST_REQ: begin
        strb.reqActive = 1'b1;
        if (dsReady) nextState = pendWrite ? ST_IDLE : ST_RSP;
      end
      ST_RSP: begin
        if (dsRspValid) begin
          strb.rdLoad = 1'b1;
          strb.rdSrc  = RD_RSP;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.capture) pendWrite <= ioWrEn;
    end
  end

  // R8: a forwarded window access closes the host port on the next cycle
  assert_stall_after_forward_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && forward) |=> !ioReady);

  // R5: a reserved destination never leaves the port busy
  assert_reserved_no_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ioSelData && idxTarget[1]) |=> ioReady);

  // R7: partial-width window access never starts a request
  assert_partial_no_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ioSelData && !ioFullBe) |=> ioReady);

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import idxBridgePkg::*;
#(
  parameter int OFF_W = 19,
  parameter logic [OFF_W-1:0] EXCL_LO = 19'h00040,
  parameter logic [OFF_W-1:0] EXCL_HI = 19'h0004F
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             ioWrEn,
  input  logic [3:0]       ioBe,
  input  logic [31:0]      ioWrData,
  output logic [1:0]       idxTarget,
  output logic             idxExcluded,
  output logic             dsReady,
  output logic             dsRspValid,
  output logic             ioRdValid,
  output logic [31:0]      ioRdData,
  output logic             regReqValid,
  input  logic             regReqReady,
  output logic             regReqWrite,
  output logic [OFF_W-1:0] regReqOffset,
  output logic [31:0]      regReqData,
  input  logic             regRspValid,
  input  logic [31:0]      regRspData,
  output logic             tblReqValid,
  input  logic             tblReqReady,
  output logic             tblReqWrite,
  output logic [OFF_W-1:0] tblReqOffset,
  output logic [31:0]      tblReqData,
  input  logic             tblRspValid,
  input  logic [31:0]      tblRspData
);

  localparam int IDX_BITS = OFF_W + 2;
  localparam logic [31:0] IDX_MASK = 32'((64'd1 << IDX_BITS) - 64'd1);

  logic [31:0]      idxReg;
  logic [OFF_W-1:0] idxOffset;
  logic [OFF_W-1:0] reqOffset;
  logic [31:0]      reqData;
  logic             reqWrite;
  logic             reqTbl;

  assign idxOffset   = idxReg[IDX_BITS-1:2];
  assign idxTarget   = idxReg[1:0];
  assign idxExcluded = (idxOffset >= EXCL_LO) && (idxOffset <= EXCL_HI);

  // pointer: one lane per byte enable, reserved bits forced to zero
  for (genvar b = 0; b < 4; b++) begin : g_idxLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) idxReg[8*b +: 8] <= 8'h00;
      else if (strb.idxWr && ioBe[b])
        idxReg[8*b +: 8] <= ioWrData[8*b +: 8] & IDX_MASK[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOffset <= '0;
      reqData   <= '0;
      reqWrite  <= 1'b0;
      reqTbl    <= 1'b0;
    end else if (strb.capture) begin
      reqOffset <= idxOffset;
      reqData   <= ioWrData;
      reqWrite  <= ioWrEn;
      reqTbl    <= idxReg[0];
    end
  end

  assign dsReady    = reqTbl ? tblReqReady : regReqReady;
  assign dsRspValid = reqTbl ? tblRspValid : regRspValid;

  assign regReqValid  = strb.reqActive && !reqTbl;
  assign regReqWrite  = reqWrite;
  assign regReqOffset = reqOffset;
  assign regReqData   = reqData;
  assign tblReqValid  = strb.reqActive && reqTbl;
  assign tblReqWrite  = reqWrite;
  assign tblReqOffset = reqOffset;
  assign tblReqData   = reqData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioRdValid <= 1'b0;
      ioRdData  <= '0;
    end else begin
      ioRdValid <= strb.rdLoad;
      if (strb.rdLoad) begin
        unique case (strb.rdSrc)
          RD_IDX:  ioRdData <= idxReg;
          RD_RSP:  ioRdData <= reqTbl ? tblRspData : regRspData;
          default: ioRdData <= '0;
        endcase
      end
    end
  end

  // R10: only one downstream space is addressed at a time
  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regReqValid && tblReqValid));

  // R8: a waiting request keeps its contents
  assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regReqValid && !regReqReady) |=>
      (regReqValid && $stable(regReqOffset) && $stable(regReqData) && $stable(regReqWrite)));

  assert_tbl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tblReqValid && !tblReqReady) |=>
      (tblReqValid && $stable(tblReqOffset) && $stable(tblReqData) && $stable(tblReqWrite)));

  // R2: reserved pointer bits never become set
  assert_idx_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idxReg & ~IDX_MASK) == 32'h0);

  // R6: no register-space request inside the excluded window
  assert_excluded_R6: assert property (@(posedge clk) disable iff (!rstN)
    regReqValid |-> !((regReqOffset >= EXCL_LO) && (regReqOffset <= EXCL_HI)));

endmodule

// File: rtl/idxWindowBridge.sv
module idxWindowBridge
  import idxBridgePkg::*;
#(
  parameter int OFF_W = 19,
  parameter logic [OFF_W-1:0] EXCL_LO = 19'h00040,
  parameter logic [OFF_W-1:0] EXCL_HI = 19'h0004F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioSelData,
  input  logic             ioWrEn,
  input  logic             ioRdEn,
  input  logic [3:0]       ioBe,
  input  logic [31:0]      ioWrData,
  output logic             ioReady,
  output logic             ioRdValid,
  output logic [31:0]      ioRdData,
  output logic             regReqValid,
  input  logic             regReqReady,
  output logic             regReqWrite,
  output logic [OFF_W-1:0] regReqOffset,
  output logic [31:0]      regReqData,
  input  logic             regRspValid,
  input  logic [31:0]      regRspData,
  output logic             tblReqValid,
  input  logic             tblReqReady,
  output logic             tblReqWrite,
  output logic [OFF_W-1:0] tblReqOffset,
  output logic [31:0]      tblReqData,
  input  logic             tblRspValid,
  input  logic [31:0]      tblRspData
);

  ctrlStrb_t  strb;
  logic [1:0] idxTarget;
  logic       idxExcluded;
  logic       dsReady;
  logic       dsRspValid;

  bridgeCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ioSelData  (ioSelData),
    .ioWrEn     (ioWrEn),
    .ioRdEn     (ioRdEn),
    .ioFullBe   (ioBe == 4'b1111),
    .idxTarget  (idxTarget),
    .idxExcluded(idxExcluded),
    .dsReady    (dsReady),
    .dsRspValid (dsRspValid),
    .ioReady    (ioReady),
    .strb       (strb)
  );

  bridgeDatapath #(.OFF_W(OFF_W), .EXCL_LO(EXCL_LO), .EXCL_HI(EXCL_HI)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ioWrEn      (ioWrEn),
    .ioBe        (ioBe),
    .ioWrData    (ioWrData),
    .idxTarget   (idxTarget),
    .idxExcluded (idxExcluded),
    .dsReady     (dsReady),
    .dsRspValid  (dsRspValid),
    .ioRdValid   (ioRdValid),
    .ioRdData    (ioRdData),
    .regReqValid (regReqValid),
    .regReqReady (regReqReady),
    .regReqWrite (regReqWrite),
    .regReqOffset(regReqOffset),
    .regReqData  (regReqData),
    .regRspValid (regRspValid),
    .regRspData  (regRspData),
    .tblReqValid (tblReqValid),
    .tblReqReady (tblReqReady),
    .tblReqWrite (tblReqWrite),
    .tblReqOffset(tblReqOffset),
    .tblReqData  (tblReqData),
    .tblRspValid (tblRspValid),
    .tblRspData  (tblRspData)
  );

  // R1: reset leaves the host port open and no request pending
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (ioReady && !regReqValid && !tblReqValid));

endmodule

// File: tb/test_idxWindowBridge.sv
`timescale 1ns/1ps
module test_idxWindowBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioSelData = 1'b0, ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [3:0]  ioBe = 4'h0;
  logic [31:0] ioWrData = '0;
  logic        ioReady, ioRdValid;
  logic [31:0] ioRdData;
  logic        regReqValid, regReqReady, regReqWrite, regRspValid;
  logic [18:0] regReqOffset, tblReqOffset;
  logic [31:0] regReqData, regRspData, tblReqData, tblRspData;
  logic        tblReqValid, tblReqReady, tblReqWrite, tblRspValid;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  idxWindowBridge i_idxWindowBridge (.*);

  // downstream models
  logic [31:0] regMem [256];
  logic [31:0] tblMem [256];
  int regCount = 0, tblCount = 0;
  logic readyTgl = 1'b0;
  logic holdReady = 1'b0;
  assign regReqReady = readyTgl && !holdReady;
  assign tblReqReady = !readyTgl && !holdReady;

  always @(posedge clk) begin
    readyTgl    <= ~readyTgl;
    regRspValid <= 1'b0;
    tblRspValid <= 1'b0;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) begin
        regMem[i] <= 32'hA500_0000 | i;
        tblMem[i] <= 32'h7B00_0000 | i;
      end
    end else begin
      if (regReqValid && regReqReady) begin
        regCount <= regCount + 1;
        if (regReqWrite) regMem[regReqOffset[7:0]] <= regReqData;
        else begin regRspValid <= 1'b1; regRspData <= regMem[regReqOffset[7:0]]; end
      end
      if (tblReqValid && tblReqReady) begin
        tblCount <= tblCount + 1;
        if (tblReqWrite) tblMem[tblReqOffset[7:0]] <= tblReqData;
        else begin tblRspValid <= 1'b1; tblRspData <= tblMem[tblReqOffset[7:0]]; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic ioOp(input logic wr, input logic sel, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    ioSelData = sel; ioWrEn = wr; ioRdEn = !wr; ioBe = be; ioWrData = wd;
    n = 0;
    while (!ioReady && n < 200) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    ioWrEn = 1'b0; ioRdEn = 1'b0;
    n = 0;
    rd = '0;
    if (!wr) begin
      while (!ioRdValid && n < 200) begin @(negedge clk); n++; end
      rd = ioRdData;
    end else begin
      while (!ioReady && n < 200) begin @(negedge clk); n++; end
    end
    if (n >= 200) chk("timeout", 32'd1, 32'd0);
  endtask

  task automatic setIdx(input logic [31:0] v);
    logic [31:0] d;
    ioOp(1'b1, 1'b0, 4'hF, v, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int rc, tc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    @(negedge clk);
    chk("R1 ready", {31'd0, ioReady}, 32'd1);
    chk("R1 no req", {30'd0, regReqValid, tblReqValid}, 32'd0);
    ioOp(1'b0, 1'b0, 4'hF, 0, rd);
    chk("R1 index reset", rd, 32'h0);

    // R2: byte-lane sweep on the pointer
    for (int b = 0; b < 16; b++) begin
      logic [31:0] exp;
      setIdx(32'h0);
      ioOp(1'b1, 1'b0, b[3:0], 32'hFFFF_FFFF, rd);
      ioOp(1'b0, 1'b0, 4'hF, 0, rd);
      exp = 32'h0;
      for (int l = 0; l < 4; l++) if (b[l]) exp[8*l +: 8] = 8'hFF;
      chk("R2 lane mask", rd, exp & 32'h001F_FFFF);
    end
    setIdx(32'h1234_5679);
    ioOp(1'b0, 1'b0, 4'hF, 0, rd);
    chk("R2 readback", rd, 32'h1234_5679 & 32'h001F_FFFF);

    // R3/R4: both spaces, several offsets, write then read back
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 8; k++) begin
        int off;
        logic [31:0] val;
        off = 3 + 29 * k;              // stays below 256, skips 40h..4Fh except 61? no: check below
        if (off >= 'h40 && off <= 'h4F) off = off + 16;
        val = 32'hC0DE_0000 ^ (t << 12) ^ (k * 32'h0101_0101);
        setIdx((off << 2) | t);
        rc = regCount; tc = tblCount;
        ioOp(1'b1, 1'b1, 4'hF, val, rd);
        @(negedge clk);
        chk("R4 write count", (t == 0) ? regCount - rc : tblCount - tc, 32'd1);
        chk("R3 other port idle", (t == 0) ? tblCount - tc : regCount - rc, 32'd0);
        chk("R3 landed", (t == 0) ? regMem[off] : tblMem[off], val);
        ioOp(1'b0, 1'b1, 4'hF, 0, rd);
        chk("R4 read data", rd, val);
      end
    end
    // R3: high offset bits forwarded unchanged
    setIdx(32'h001F_FFFD);
    ioOp(1'b1, 1'b1, 4'hF, 32'h5555_AAAA, rd);
    @(negedge clk);
    chk("R3 top offset", tblMem[8'hFF], 32'h5555_AAAA);

    // R5: reserved destination codes
    for (int t = 2; t < 4; t++) begin
      setIdx(32'h0000_0010 | t);
      rc = regCount; tc = tblCount;
      ioOp(1'b1, 1'b1, 4'hF, 32'hDEAD_BEEF, rd);
      ioOp(1'b0, 1'b1, 4'hF, 0, rd);
      chk("R5 read zero", rd, 32'h0);
      chk("R5 no request", (regCount - rc) + (tblCount - tc), 32'd0);
    end

    // R6: sweep around the excluded window on both spaces
    for (int t = 0; t < 2; t++) begin
      for (int off = 'h3C; off < 'h54; off++) begin
        bit blocked;
        blocked = (t == 0) && off >= 'h40 && off <= 'h4F;
        setIdx((off << 2) | t);
        rc = regCount; tc = tblCount;
        ioOp(1'b1, 1'b1, 4'hF, 32'h6000_0000 | off, rd);
        ioOp(1'b0, 1'b1, 4'hF, 0, rd);
        chk("R6 read", rd, blocked ? 32'h0 : (32'h6000_0000 | off));
        chk("R6 requests", (regCount - rc) + (tblCount - tc), blocked ? 32'd0 : 32'd2);
      end
    end

    // R7: every partial byte-enable value
    setIdx(32'h0000_0014);  // register offset 5
    for (int b = 0; b < 15; b++) begin
      rc = regCount;
      ioOp(1'b1, 1'b1, b[3:0], 32'h9999_9999, rd);
      ioOp(1'b0, 1'b1, b[3:0], 0, rd);
      chk("R7 read zero", rd, 32'h0);
      chk("R7 no request", regCount - rc, 32'd0);
      chk("R7 unchanged", regMem[5], 32'hA500_0005);
    end

    // R8/R9: stall during an outstanding read, pointer write waits
    setIdx(32'h0000_0020);  // register offset 8
    @(negedge clk);
    holdReady = 1'b1;
    ioSelData = 1'b1; ioRdEn = 1'b1; ioBe = 4'hF;
    @(posedge clk);
    @(negedge clk);
    ioRdEn = 1'b0;
    chk("R8 ready low", {31'd0, ioReady}, 32'd0);
    chk("R8 request offset", {13'd0, regReqOffset}, 32'd8);
    ioSelData = 1'b0; ioWrEn = 1'b1; ioWrData = 32'h0000_0031;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 still stalled", {31'd0, ioReady}, 32'd0);
      chk("R8 request held", {31'd0, regReqValid}, 32'd1);
    end
    holdReady = 1'b0;
    begin
      int n = 0;
      while (!ioRdValid && n < 50) begin @(negedge clk); n++; end
    end
    chk("R9 read uses captured pointer", ioRdData, 32'hA500_0008);
    @(posedge clk);
    @(negedge clk);
    ioWrEn = 1'b0;
    ioOp(1'b0, 1'b0, 4'hF, 0, rd);
    chk("R9 pointer taken after", rd, 32'h0000_0031);
    tc = tblCount;
    ioOp(1'b0, 1'b1, 4'hF, 0, rd);
    chk("R9 later access uses new pointer", rd, 32'h7B00_000C);
    chk("R10 table only", tblCount - tc, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule